// File: doc/BRIEF.md
# Wrap-Loopback Word Serializer

This block turns a stream of 10-bit line-coded words into a serial bit stream, one bit per clock. It runs entirely on the serial bit clock. A free-running modulo-ten counter marks word boundaries and raises a one-cycle `word_load` strobe. On the edge that ends that strobe cycle the block captures `tx_word` and `wrap_en` into a holding stage. On the same edge it moves the word captured one boundary earlier into the shift stage. Each word therefore reaches the serial outputs one full word period after it is captured, and words follow each other with no gap.

The wrap request travels with its word. A word captured with `wrap_en` high is sent on `loop_out`, which feeds the local receiver, while `line_out` is parked at logic 1 for that whole word period. A word captured with `wrap_en` low is sent on `line_out`, and `loop_out` stays at 0. Because the path is chosen once per word, neither output ever carries part of a word. Upstream logic uses `word_load` as its data-request pulse, since no word-rate clock exists here.

Top module: `wrap_serializer`

## Requirements
- R1: While `rst` is high, and for the first 19 clock cycles after it falls, `line_out` is 1 and `loop_out` is 0.
- R2: `word_load` is high for exactly one cycle in every ten. It is first high in the cycle after the 9th rising edge following reset release, and it is 0 during reset.
- R3: `tx_word` is sampled only on the rising edge that ends a `word_load` cycle. Values it holds at any other edge have no effect on either output.
- R4: A word captured at boundary k is emitted during the ten cycles after boundary k+1. Bit 0 goes first, then bits 1 to 9 in rising order, one bit per clock.
- R5: Consecutive words are sent back to back, with no idle bit between bit 9 of one word and bit 0 of the next.
- R6: A word captured with `wrap_en` = 1 appears bit by bit on `loop_out`, and `line_out` holds 1 for all ten of its cycles.
- R7: A word captured with `wrap_en` = 0 appears on `line_out`, and `loop_out` holds 0 for all ten of its cycles.
- R8: `wrap_en` is sampled only at the boundary edge, together with the word. Toggling it between boundaries does not change either output.
- R9: A reset raised in the middle of a word discards every word in flight. The outputs return to the R1 idle levels, and counting restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_word | input | 10 | Encoded parallel word, sampled at boundaries |
| wrap_en | input | 1 | Loopback request, sampled with the word |
| word_load | output | 1 | One-cycle boundary strobe; inputs are taken at its closing edge |
| line_out | output | 1 | External serial output; parked at 1 when idle or wrapped |
| loop_out | output | 1 | Internal loopback serial output; 0 unless wrapped |

## Verification
The bench targets the two-stage latency. A design that sent a word in the period right after its capture would shift every bit by ten cycles, and a wrong shift direction would reverse each word. It also switches `tx_word` and `wrap_en` between boundaries. A design that samples them continuously would corrupt bits or flip paths in the middle of a word. It mixes wrapped and unwrapped words back to back, which catches a wrap flag that is not carried along with its word: that flaw moves the path change by one word. Finally, it applies a reset in the middle of a word, which exposes stale words left in the holding stage after restart.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

   // Which end of the parallel word goes out on the wire first.
   typedef enum logic {
      ORDER_LSB_FIRST = 1'b0,
      ORDER_MSB_FIRST = 1'b1
   } bit_order_e;

   // Width of a counter that must hold values 0 .. span-1.
   function automatic int unsigned span_bits(input int unsigned span);
      return (span > 1) ? $clog2(span) : 1;
   endfunction

endpackage

// File: rtl/wrs_boundary_ctr.sv
module wrs_boundary_ctr
   import wrs_pkg::*;
#(
   parameter int unsigned SPAN = 10
) (
   input  logic clk,
   input  logic rst,
   output logic load_stb
);

   localparam int unsigned CW = span_bits(SPAN);
   localparam logic [CW-1:0] LAST = CW'(SPAN - 1);

   if (SPAN < 2) begin : g_bad_span
      $error("wrs_boundary_ctr: SPAN must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (cnt_q == LAST) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign load_stb = (cnt_q == LAST);

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LAST); // R2

   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      load_stb |=> !load_stb); // R2

endmodule

// File: rtl/wrs_word_pipe.sv
module wrs_word_pipe
   import wrs_pkg::*;
#(
   parameter int unsigned WORD_W = 10,
   parameter bit_order_e  ORDER  = ORDER_LSB_FIRST
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_stb,
   input  logic [WORD_W-1:0] word_in,
   input  logic              wrap_in,
   output logic              ser_bit,
   output logic              ser_vld,
   output logic              ser_wrap
);

   if (WORD_W < 2) begin : g_bad_width
      $error("wrs_word_pipe: WORD_W must be at least 2");
   end

   // holding stage: filled at each boundary
   logic [WORD_W-1:0] hold_q;
   logic              hold_vld;
   logic              hold_wrap;

   // shift stage: word currently on the wire
   logic [WORD_W-1:0] sh_q;
   logic [WORD_W-1:0] sh_next;
   logic              sh_vld;
   logic              sh_wrap;

   if (ORDER == ORDER_LSB_FIRST) begin : g_lsb
      assign ser_bit = sh_q[0];
      assign sh_next = {1'b0, sh_q[WORD_W-1:1]};
   end else begin : g_msb
      assign ser_bit = sh_q[WORD_W-1];
      assign sh_next = {sh_q[WORD_W-2:0], 1'b0};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_q    <= '0;
         hold_vld  <= 1'b0;
         hold_wrap <= 1'b0;
         sh_q      <= '0;
         sh_vld    <= 1'b0;
         sh_wrap   <= 1'b0;
      end else if (load_stb) begin
         hold_q    <= word_in;
         hold_vld  <= 1'b1;
         hold_wrap <= wrap_in;
         sh_q      <= hold_q;
         sh_vld    <= hold_vld;
         sh_wrap   <= hold_wrap;
      end else begin
         sh_q      <= sh_next;
      end
   end

   assign ser_vld  = sh_vld;
   assign ser_wrap = sh_wrap;

   AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
      !load_stb |=> $stable(hold_q) && $stable(hold_wrap)); // R3

   AST_PATH_FIXED_MIDWORD: assert property (@(posedge clk) disable iff (rst)
      !load_stb |=> $stable(sh_wrap)); // R8

   AST_NO_GAP: assert property (@(posedge clk) disable iff (rst)
      (load_stb && hold_vld) |=> ser_vld); // R5

endmodule

// File: rtl/wrs_wrap_mux.sv
module wrs_wrap_mux #(
   parameter logic LINE_HOLD = 1'b1,
   parameter logic LOOP_IDLE = 1'b0
) (
   input  logic ser_bit,
   input  logic ser_vld,
   input  logic ser_wrap,
   output logic line_out,
   output logic loop_out
);

   always_comb begin
      line_out = LINE_HOLD;
      loop_out = LOOP_IDLE;
      if (ser_vld) begin
         if (ser_wrap) begin
            loop_out = ser_bit;
         end else begin
            line_out = ser_bit;
         end
      end
   end

endmodule

// File: rtl/wrap_serializer.sv
module wrap_serializer
   import wrs_pkg::*;
#(
   parameter int unsigned WORD_W    = 10,
   parameter bit_order_e  ORDER     = ORDER_LSB_FIRST,
   parameter logic        LINE_HOLD = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              wrap_en,
   output logic              word_load,
   output logic              line_out,
   output logic              loop_out
);

   localparam logic LOOP_IDLE = 1'b0;

   logic load_stb;
   logic ser_bit;
   logic ser_vld;
   logic ser_wrap;

   wrs_boundary_ctr #(
      .SPAN (WORD_W)
   ) u_ctr (
      .clk      (clk),
      .rst      (rst),
      .load_stb (load_stb)
   );

   wrs_word_pipe #(
      .WORD_W (WORD_W),
      .ORDER  (ORDER)
   ) u_pipe (
      .clk      (clk),
      .rst      (rst),
      .load_stb (load_stb),
      .word_in  (tx_word),
      .wrap_in  (wrap_en),
      .ser_bit  (ser_bit),
      .ser_vld  (ser_vld),
      .ser_wrap (ser_wrap)
   );

   wrs_wrap_mux #(
      .LINE_HOLD (LINE_HOLD),
      .LOOP_IDLE (LOOP_IDLE)
   ) u_mux (
      .ser_bit  (ser_bit),
      .ser_vld  (ser_vld),
      .ser_wrap (ser_wrap),
      .line_out (line_out),
      .loop_out (loop_out)
   );

   assign word_load = load_stb;

   AST_LINE_PARKED_IN_WRAP: assert property (@(posedge clk) disable iff (rst)
      ser_wrap |-> line_out == LINE_HOLD); // R6

   AST_LOOP_QUIET_OUT_OF_WRAP: assert property (@(posedge clk) disable iff (rst)
      !ser_wrap |-> loop_out == LOOP_IDLE); // R7

   AST_FLUSHED_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> !ser_vld && line_out == LINE_HOLD); // R9

endmodule

// File: tb/wrap_serializer_bench.sv
`timescale 1ns/1ps
module wrap_serializer_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [9:0] tx_word = '0;
   logic       wrap_en = 1'b0;
   logic       word_load;
   logic       line_out;
   logic       loop_out;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   logic [9:0] wq[$];
   bit         wrq[$];

   always #2 clk = ~clk;

   wrap_serializer u_wrap_serializer (
      .clk       (clk),
      .rst       (rst),
      .tx_word   (tx_word),
      .wrap_en   (wrap_en),
      .word_load (word_load),
      .line_out  (line_out),
      .loop_out  (loop_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // R1: idle levels during reset; releases so the next posedge is edge 1
   task automatic do_reset();
      rst = 1'b1;
      tx_word = '0;
      wrap_en = 1'b0;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      chk("R1", line_out, 1);
      chk("R1", loop_out, 0);
      chk("R2", word_load, 0);
      rst = 1'b0;
   endtask

   // Streams the queued words after a reset and checks every cycle.
   task automatic run_stream(input bit jitter);
      int n = wq.size();
      do_reset();
      for (int c = 1; c <= 10 * n + 19; c++) begin
         int exp_line;
         int exp_loop;
         string lbl_line;
         string lbl_loop;
         bit exp_ld;
         @(negedge clk);
         exp_ld = (c % 10 == 9);
         chk("R2", word_load, exp_ld);
         if (c < 20) begin
            exp_line = 1; exp_loop = 0;
            lbl_line = "R1"; lbl_loop = "R1";
         end else begin
            int k = (c - 20) / 10;
            int i = (c - 20) % 10;
            int b = wq[k][i];
            if (wrq[k]) begin
               exp_line = 1; exp_loop = b;
               lbl_line = "R6"; lbl_loop = "R6";
            end else begin
               exp_line = b; exp_loop = 0;
               lbl_line = (c < 30) ? "R4" : "R5";
               lbl_loop = "R7";
            end
            if (jitter) begin
               lbl_line = "R3"; lbl_loop = "R8";
            end
         end
         chk(lbl_line, line_out, exp_line);
         chk(lbl_loop, loop_out, exp_loop);
         if (exp_ld) begin
            int kk = (c - 9) / 10;
            if (kk < n) begin
               tx_word = wq[kk];
               wrap_en = wrq[kk];
            end else begin
               tx_word = '0;
               wrap_en = 1'b0;
            end
         end else if (jitter) begin
            tx_word = ~tx_word ^ 10'(c);
            wrap_en = ~wrap_en;
         end
      end
   endtask

   task automatic t_plain();   // R4 R5 R7
      wq = '{10'h17C, 10'h283, 10'h3FF, 10'h000, 10'h155, 10'h001};
      wrq = '{0, 0, 0, 0, 0, 0};
      run_stream(1'b0);
   endtask

   task automatic t_wrap_mix();   // R6 R7
      wq = '{10'h2AA, 10'h0F3, 10'h301, 10'h1C7, 10'h200};
      wrq = '{1, 1, 0, 1, 0};
      run_stream(1'b0);
   endtask

   task automatic t_jitter();   // R3 R8
      wq = '{10'h0FA, 10'h305, 10'h1E1, 10'h3C3};
      wrq = '{0, 1, 0, 1};
      run_stream(1'b1);
   endtask

   task automatic t_midword_reset();   // R9
      do_reset();
      for (int c = 1; c <= 25; c++) begin
         @(negedge clk);
         if (c % 10 == 9) begin
            tx_word = 10'h000;
            wrap_en = 1'b1;
         end
      end
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R9", line_out, 1);
      chk("R9", loop_out, 0);
      chk("R9", word_load, 0);
      rst = 1'b0;
      tx_word = 10'h3FF;
      wrap_en = 1'b0;
      for (int c = 1; c <= 19; c++) begin
         @(negedge clk);
         chk("R9", line_out, 1);
         chk("R9", loop_out, 0);
         chk("R9", word_load, (c % 10 == 9) ? 1 : 0);
      end
   endtask

   initial begin
      t_plain();
      t_wrap_mix();
      t_jitter();
      t_midword_reset();
      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      #(4 * 200000);
      if (!finished) begin
         finished = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule